// File: doc/BRIEF.md
# Timing Reference Link Selector

This block decides which member link of an inverse-multiplexed ATM group serves as the transmit timing reference. Each cycle it samples a two-bit transmit state for every link and a group start-up pulse. It keeps a registered choice of reference link.

The index it drives is carried to the far end in the timing-information field of outgoing control cells. The transmit cell clock is taken from the link it names. Building those cells and deriving that clock are done elsewhere.

The choice is sticky. A new reference is picked on start-up, or when the current reference is downgraded in one of two specific ways while a better-placed alternative exists. At any other time the current reference is kept, even when a better link comes up. When a pick is made, Active links win over Usable ones and Usable links win over Unusable ones. Within a class, the lowest-numbered link wins.

Top module: `trl_selector`

## Requirements
- R1: Link state codes are 0 = Not In Group, 1 = Unusable, 2 = Usable, 3 = Active, with link k on bits [2k+1:2k] of `link_state_i`. When a pick is made and any link is Active, the chosen link is an Active one.
- R2: When a pick is made and no link is Active, a Usable link is chosen if one exists, otherwise an Unusable link.
- R3: Among candidates of the same state, the lowest-numbered link is chosen.
- R4: A start-up pulse forces a pick regardless of the current reference and takes precedence over every other rule.
- R5: A pick is made when the reference was Active in the previous sample and is no longer Active, while some other link is Active.
- R6: A pick is made when the reference was Usable in the previous sample and is now Unusable or Not In Group, while some other link is Active or Usable.
- R7: In every other situation the reference index is unchanged. This includes a better link appearing, the reference leaving Active with no other Active link, and the reference falling from Unusable to Not In Group.
- R8: `ref_chg_o` is high for exactly one cycle when the index takes a new value, or when valid rises. It is low otherwise, including when a pick returns the index already held.
- R9: When every link is Not In Group, `ref_valid_o` goes low, the index is held and no strobe is raised. Valid comes back only at a start-up pulse that finds a member link.
- R10: After synchronous reset, `ref_valid_o` = 0, `ref_idx_o` = 0 and `ref_chg_o` = 0.
- R11: All outputs are registered. They reflect the inputs sampled at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Group start-up pulse, forces a pick |
| link_state_i | input | 2*N_LINKS | Packed per-link transmit state codes |
| ref_idx_o | output | IDX_W | Index of the timing reference link |
| ref_valid_o | output | 1 | Reference index is meaningful |
| ref_chg_o | output | 1 | One-cycle strobe on a new reference |

## Verification
The bound checker tests several rules on every cycle:
- the class priority of every strobed pick;
- the start-up forcing;
- the all-out-of-group invalidation;
- the consistency of the strobe with the index and valid history;
- stability of the index whenever there is no start pulse and the reference link's state is unchanged.

The two downgrade triggers, lowest-index tie breaking, and the choices not to reselect depend on the history of several links. The bench scenarios show these by walking the reference through Active-to-Usable, Usable-to-Unusable and Unusable-to-out transitions, with and without alternatives, and by comparing every cycle of a long seeded random run with a bench model.

// File: rtl/trl_pkg.sv
package trl_pkg;

  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    LS_OUT      = 2'd0,
    LS_UNUSABLE = 2'd1,
    LS_USABLE   = 2'd2,
    LS_ACTIVE   = 2'd3
  } link_st_e;

  localparam int N_CLASS = 3;
  localparam int CL_ACT  = 0;
  localparam int CL_USB  = 1;
  localparam int CL_UNU  = 2;

endpackage

// File: rtl/trl_class_scan.sv
module trl_class_scan
  import trl_pkg::*;
#(
  parameter int N_LINKS = 8
) (
  input  logic [N_LINKS*ST_W-1:0] states_i,
  output logic [N_LINKS-1:0]      act_mask_o,
  output logic [N_LINKS-1:0]      usb_mask_o,
  output logic [N_LINKS-1:0]      unu_mask_o
);

  for (genvar k = 0; k < N_LINKS; k++) begin : g_link
    link_st_e st;
    assign st            = link_st_e'(states_i[k*ST_W +: ST_W]);
    assign act_mask_o[k] = (st == LS_ACTIVE);
    assign usb_mask_o[k] = (st == LS_USABLE);
    assign unu_mask_o[k] = (st == LS_UNUSABLE);
  end

endmodule

// File: rtl/trl_low_pick.sv
module trl_low_pick #(
  parameter int N_LINKS = 8,
  parameter int IDX_W   = 3
) (
  input  logic [N_LINKS-1:0] mask_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_LINKS - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/trl_reselect_ctrl.sv
module trl_reselect_ctrl
  import trl_pkg::*;
#(
  parameter int N_LINKS = 8,
  parameter int IDX_W   = 3
) (
  input  logic [N_LINKS*ST_W-1:0] states_i,
  input  logic [N_LINKS-1:0]      act_mask_i,
  input  logic [N_LINKS-1:0]      usb_mask_i,
  input  logic                    ref_valid_i,
  input  logic [IDX_W-1:0]        ref_idx_i,
  input  link_st_e                ref_st_q_i,
  output logic                    trig_o
);

  link_st_e           ref_now;
  logic [N_LINKS-1:0] ref_oh;
  logic               other_act;
  logic               other_use;
  logic               left_active;
  logic               left_usable;

  assign ref_now   = link_st_e'(states_i[ref_idx_i*ST_W +: ST_W]);
  assign ref_oh    = N_LINKS'(1) << ref_idx_i;
  assign other_act = |(act_mask_i & ~ref_oh);
  assign other_use = |((act_mask_i | usb_mask_i) & ~ref_oh);

  // Active -> anything lower
  assign left_active = (ref_st_q_i == LS_ACTIVE) && (ref_now != LS_ACTIVE);
  // Usable -> Unusable or out of group
  assign left_usable = (ref_st_q_i == LS_USABLE) &&
                       ((ref_now == LS_UNUSABLE) || (ref_now == LS_OUT));

  assign trig_o = ref_valid_i &&
                  ((left_active && other_act) || (left_usable && other_use));

endmodule

// File: rtl/trl_selector.sv
module trl_selector
  import trl_pkg::*;
#(
  parameter int N_LINKS = 8,
  localparam int IDX_W  = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [N_LINKS*ST_W-1:0] link_state_i,
  output logic [IDX_W-1:0]        ref_idx_o,
  output logic                    ref_valid_o,
  output logic                    ref_chg_o
);

  logic [N_LINKS-1:0] cls_mask  [N_CLASS];
  logic               cls_found [N_CLASS];
  logic [IDX_W-1:0]   cls_idx   [N_CLASS];

  trl_class_scan #(.N_LINKS(N_LINKS)) u_scan (
    .states_i   (link_state_i),
    .act_mask_o (cls_mask[CL_ACT]),
    .usb_mask_o (cls_mask[CL_USB]),
    .unu_mask_o (cls_mask[CL_UNU])
  );

  for (genvar c = 0; c < N_CLASS; c++) begin : g_pick
    trl_low_pick #(.N_LINKS(N_LINKS), .IDX_W(IDX_W)) u_pick (
      .mask_i  (cls_mask[c]),
      .found_o (cls_found[c]),
      .idx_o   (cls_idx[c])
    );
  end

  link_st_e ref_st_q;
  logic     trig;

  trl_reselect_ctrl #(.N_LINKS(N_LINKS), .IDX_W(IDX_W)) u_ctrl (
    .states_i    (link_state_i),
    .act_mask_i  (cls_mask[CL_ACT]),
    .usb_mask_i  (cls_mask[CL_USB]),
    .ref_valid_i (ref_valid_o),
    .ref_idx_i   (ref_idx_o),
    .ref_st_q_i  (ref_st_q),
    .trig_o      (trig)
  );

  logic             any_member;
  logic [IDX_W-1:0] best_idx;
  logic             do_pick;
  logic [IDX_W-1:0] idx_d;
  logic             valid_d;
  logic             chg_d;

  assign any_member = cls_found[CL_ACT] | cls_found[CL_USB] | cls_found[CL_UNU];
  assign do_pick    = start_i | trig;

  always_comb begin
    if (cls_found[CL_ACT])      best_idx = cls_idx[CL_ACT];
    else if (cls_found[CL_USB]) best_idx = cls_idx[CL_USB];
    else                        best_idx = cls_idx[CL_UNU];
  end

  always_comb begin
    idx_d   = ref_idx_o;
    valid_d = ref_valid_o;
    chg_d   = 1'b0;
    if (!any_member) begin
      valid_d = 1'b0;
    end else if (do_pick) begin
      idx_d   = best_idx;
      valid_d = 1'b1;
      chg_d   = (best_idx != ref_idx_o) || !ref_valid_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_idx_o   <= '0;
      ref_valid_o <= 1'b0;
      ref_chg_o   <= 1'b0;
      ref_st_q    <= LS_OUT;
    end else begin
      ref_idx_o   <= idx_d;
      ref_valid_o <= valid_d;
      ref_chg_o   <= chg_d;
      ref_st_q    <= link_st_e'(link_state_i[idx_d*ST_W +: ST_W]);
    end
  end

endmodule

// File: rtl/trl_selector_chk.sv
module trl_selector_chk
  import trl_pkg::*;
#(
  parameter int N_LINKS = 8,
  parameter int IDX_W   = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start_i,
  input logic [N_LINKS*ST_W-1:0] link_state_i,
  input logic [IDX_W-1:0]        ref_idx_o,
  input logic                    ref_valid_o,
  input logic                    ref_chg_o
);

  logic [N_LINKS*ST_W-1:0] st_q;
  logic [N_LINKS-1:0]      act_q;
  logic [N_LINKS-1:0]      usb_q;
  logic                    all_out;

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= link_state_i;
  end

  for (genvar k = 0; k < N_LINKS; k++) begin : g_q
    assign act_q[k] = (st_q[k*ST_W +: ST_W] == LS_ACTIVE);
    assign usb_q[k] = (st_q[k*ST_W +: ST_W] == LS_USABLE);
  end

  assign all_out = (link_state_i == '0);

  p_act_first_r1: assert property (@(posedge clk) disable iff (rst)
    (ref_chg_o && act_q != '0) |-> act_q[ref_idx_o]);

  p_usable_next_r2: assert property (@(posedge clk) disable iff (rst)
    (ref_chg_o && act_q == '0 && usb_q != '0) |-> usb_q[ref_idx_o]);

  p_start_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (start_i && !all_out) |=> ref_valid_o);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!start_i && ref_valid_o &&
     st_q[ref_idx_o*ST_W +: ST_W] == link_state_i[ref_idx_o*ST_W +: ST_W])
    |=> $stable(ref_idx_o));

  p_chg_cause_r8: assert property (@(posedge clk) disable iff (rst)
    ref_chg_o |-> (ref_valid_o &&
                   (ref_idx_o != $past(ref_idx_o) || !$past(ref_valid_o))));

  p_chg_seen_r8: assert property (@(posedge clk) disable iff (rst)
    (ref_valid_o && $past(ref_valid_o) && ref_idx_o != $past(ref_idx_o))
    |-> ref_chg_o);

  p_rise_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_valid_o) |-> ref_chg_o);

  p_all_out_r9: assert property (@(posedge clk) disable iff (rst)
    all_out |=> (!ref_valid_o && !ref_chg_o && $stable(ref_idx_o)));

endmodule

bind trl_selector trl_selector_chk #(.N_LINKS(N_LINKS), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .link_state_i (link_state_i),
  .ref_idx_o    (ref_idx_o),
  .ref_valid_o  (ref_valid_o),
  .ref_chg_o    (ref_chg_o)
);

// File: tb/trl_selector_tb.sv
module trl_selector_tb;

  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [2*N-1:0] link_state_i = '0;
  logic [IW-1:0] ref_idx_o;
  logic          ref_valid_o;
  logic          ref_chg_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [1:0] st [N];
  int  m_idx = 0;
  bit  m_valid = 1'b0;
  bit  m_chg = 1'b0;
  int  m_refst = 0;

  always #4 clk = ~clk;

  trl_selector #(.N_LINKS(N)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .link_state_i(link_state_i),
    .ref_idx_o(ref_idx_o), .ref_valid_o(ref_valid_o), .ref_chg_o(ref_chg_o)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int best_link();
    for (int c = 3; c >= 1; c--)
      for (int i = 0; i < N; i++)
        if (st[i] == 2'(c)) return i;
    return -1;
  endfunction

  function automatic bit other_at_least(int lvl);
    for (int i = 0; i < N; i++)
      if (i != m_idx && int'(st[i]) >= lvl) return 1'b1;
    return 1'b0;
  endfunction

  // Expected next outputs, from the requirements
  task automatic model_step(bit s);
    int b;
    bit pick;
    int cur;
    b = best_link();
    cur = int'(st[m_idx]);
    pick = s;
    if (!s && m_valid) begin
      if (m_refst == 3 && cur != 3 && other_at_least(3)) pick = 1'b1;
      if (m_refst == 2 && cur <= 1 && other_at_least(2)) pick = 1'b1;
    end
    m_chg = 1'b0;
    if (b < 0) m_valid = 1'b0;
    else if (pick) begin
      m_chg   = (b != m_idx) || !m_valid;
      m_idx   = b;
      m_valid = 1'b1;
    end
    m_refst = int'(st[m_idx]);
  endtask

  task automatic step(string req, bit s);
    @(negedge clk);
    start_i = s;
    for (int i = 0; i < N; i++) link_state_i[2*i +: 2] = st[i];
    @(posedge clk);
    model_step(s);
    @(negedge clk);
    start_i = 1'b0;
    check({req, " idx"},   int'(ref_idx_o),   m_idx);
    check({req, " valid"}, int'(ref_valid_o), int'(m_valid));
    check({req, " chg"},   int'(ref_chg_o),   int'(m_chg));
  endtask

  task automatic expect_out(string req, int idx, int v, int c);
    check({req, " lit idx"},   int'(ref_idx_o),   idx);
    check({req, " lit valid"}, int'(ref_valid_o), v);
    check({req, " lit chg"},   int'(ref_chg_o),   c);
  endtask

  task automatic set_all(int v);
    for (int i = 0; i < N; i++) st[i] = 2'(v);
  endtask

  initial begin
    set_all(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    expect_out("R10", 0, 0, 0);

    step("R9 start all out", 1'b1);
    expect_out("R9", 0, 0, 0);

    st[2] = 2; st[5] = 3; st[6] = 3;
    step("R4 start", 1'b1);
    expect_out("R1 R3 R4", 5, 1, 1);
    step("R8 idle", 1'b0);
    expect_out("R8", 5, 1, 0);

    st[1] = 3;
    step("R7 better", 1'b0);
    expect_out("R7", 5, 1, 0);

    st[5] = 2;
    step("R5 leave active", 1'b0);
    expect_out("R5", 1, 1, 1);

    st[1] = 2; st[6] = 2;
    step("R7 no other active", 1'b0);
    expect_out("R7", 1, 1, 0);

    st[1] = 1;
    step("R6 usable drop", 1'b0);
    expect_out("R6", 2, 1, 1);

    set_all(0); st[2] = 1; st[3] = 1; st[4] = 1;
    step("R7 unusable only", 1'b0);
    expect_out("R7", 2, 1, 0);

    step("R8 same pick", 1'b1);
    expect_out("R8", 2, 1, 0);

    st[4] = 2;
    step("R2 start", 1'b1);
    expect_out("R2", 4, 1, 1);

    set_all(0);
    step("R9 all out", 1'b0);
    expect_out("R9", 4, 0, 0);
    st[0] = 3;
    step("R9 no start", 1'b0);
    expect_out("R9", 4, 0, 0);
    step("R4 restart", 1'b1);
    expect_out("R4", 0, 1, 1);

    st[0] = 1; st[3] = 2;
    step("R7 active to unusable", 1'b0);
    expect_out("R7", 0, 1, 0);
    st[0] = 0;
    step("R7 unusable to out", 1'b0);
    expect_out("R7", 0, 1, 0);

    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      bit s;
      s = ($urandom_range(39) == 0);
      for (int i = 0; i < N; i++)
        if ($urandom_range(5) == 0) st[i] = 2'($urandom_range(3));
      if ($urandom_range(199) == 0) set_all(0);
      step("R11 random", s);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run ended)");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule